// File: doc/BRIEF.md
# Word-Serial AES-128 Encryption Engine

This block encrypts a stream of (key, plaintext) pairs with AES-128 and returns one 128-bit ciphertext per pair. Pairs enter through a ready/valid handshake. Results leave through a second ready/valid handshake. The datapath is one 32-bit word wide. Four byte-substitution units, followed by a pipeline register, carry every substitution in the cipher, including the one in the key schedule. The round key is expanded in place, one round at a time, inside a single 128-bit key register. No expanded key is stored.

Each round uses five issue slots. In the first slot the rotated last key word goes to the substitution units while the whole state is byte-rotated row by row. The other four slots send the state columns in order. The key update and the column mixing with round-key addition run one slot behind their issue, reading from the pipeline register. A separate output register takes the finished block. This lets the next pair load during the final slot of the current one, so the substitution units never sit idle while work is queued. If the previous result has not yet been taken, the new encryption runs forward and then waits at its final slot.

Top module: `aes_wse_enc`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. While no encryption is in progress `in_ready` stays 1. A pair is accepted on a rising edge where `in_valid` and `in_ready` are both 1.
- R2: `out_data` equals AES-128 of `in_text` under `in_key`. Byte 0 of each 128-bit value is bits [127:120]. Key 000102…0F with plaintext 00112233…FF gives 69C4E0D86A7B0430D8CDB78070B4C55A.
- R3: When the output register is free, `out_valid` rises at the 51st rising edge after the accepting edge. Counting the accept cycle and the first visible cycle, this is 53 cycles.
- R4: An encryption runs 10 rounds of 5 slots each. Within a round the slot index steps by one from 0 to 4. After slot 4 of rounds 1 to 9 comes slot 0 of the next round.
- R5: While an encryption is in progress, `in_ready` is 0 except in slot 4 of round 10.
- R6: Once `out_valid` is 1, it stays 1 and `out_data` stays unchanged until a cycle with `out_ready` = 1.
- R7: If an unconsumed result still sits in the output register, a newer encryption halts at slot 4 of round 10 and the old result stays on `out_data`. On the edge that consumes the old result the halted encryption resumes. `out_valid` is then 0 for exactly one cycle and comes back with the new ciphertext.
- R8: With `in_valid` and `out_ready` held at 1, consecutive pairs are accepted exactly 50 cycles apart.
- R9: In slot 4 of round 10, `in_ready` follows `out_ready` in the same cycle when the output register is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A key/plaintext pair is offered |
| in_ready | output | 1 | The engine takes the offered pair on this edge |
| in_key | input | 128 | Cipher key, byte 0 in bits [127:120] |
| in_text | input | 128 | Plaintext block, byte 0 in bits [127:120] |
| out_valid | output | 1 | `out_data` holds a finished ciphertext |
| out_ready | input | 1 | The consumer takes the ciphertext on this edge |
| out_data | output | 128 | Ciphertext, byte 0 in bits [127:120] |

## Verification
The published known-answer pair and all-zero and all-one blocks anchor the byte ordering and the round-constant sequence. A constant key or text would hide a word-order or lane swap; random pairs would not. Random pairs under random output back-pressure test whether results survive being held and stay in order. A directed run where the second result lands while the first is still unconsumed isolates the stall-and-resume path and its one-cycle gap. Pairs offered back to back with a free consumer measure the 50-cycle spacing and the overlap of a load with the final slot.

// File: rtl/aes_wse_pkg.sv
package aes_wse_pkg;
  localparam int WORD_W = 32;
  localparam int BLK_W  = 128;
  localparam int NWORDS = BLK_W / WORD_W;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  // a^254 through repeated squaring; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = a;
    acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] sbox_byte(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
           {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [WORD_W-1:0] rot_word(input logic [WORD_W-1:0] w);
    return {w[WORD_W-9:0], w[WORD_W-1 -: 8]};
  endfunction

  function automatic logic [WORD_W-1:0] get_word(input logic [BLK_W-1:0] v, input int idx);
    return v[BLK_W-1-WORD_W*idx -: WORD_W];
  endfunction

  function automatic logic [WORD_W-1:0] mix_col(input logic [WORD_W-1:0] w);
    logic [7:0] a0, a1, a2, a3;
    a0 = w[31:24]; a1 = w[23:16]; a2 = w[15:8]; a3 = w[7:0];
    return {gf_dbl(a0) ^ gf_dbl(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ gf_dbl(a1) ^ gf_dbl(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ gf_dbl(a2) ^ gf_dbl(a3) ^ a3,
            gf_dbl(a0) ^ a0 ^ a1 ^ a2 ^ gf_dbl(a3)};
  endfunction

  // row r of column c takes the byte of row r from column (c+r) mod 4
  function automatic logic [BLK_W-1:0] shift_rows(input logic [BLK_W-1:0] s);
    logic [BLK_W-1:0] o;
    for (int c = 0; c < NWORDS; c++) begin
      for (int r = 0; r < 4; r++) begin
        o[BLK_W-1-8*(4*c+r) -: 8] = s[BLK_W-1-8*(4*((c+r)%NWORDS)+r) -: 8];
      end
    end
    return o;
  endfunction

  function automatic logic [7:0] rcon(input int rnd);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < 16; i++) begin
      if (i < rnd) r = gf_dbl(r);
    end
    return r;
  endfunction

  // t is the substituted, rotated last word of the current key
  function automatic logic [BLK_W-1:0] next_key(input logic [BLK_W-1:0] k,
                                                input logic [WORD_W-1:0] t,
                                                input logic [7:0] rc);
    logic [WORD_W-1:0] w0, w1, w2, w3;
    w0 = k[127:96] ^ t ^ {rc, 24'h000000};
    w1 = k[95:64] ^ w0;
    w2 = k[63:32] ^ w1;
    w3 = k[31:0] ^ w2;
    return {w0, w1, w2, w3};
  endfunction
endpackage

// File: rtl/aes_wse_sbox_pipe.sv
module aes_wse_sbox_pipe #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  import aes_wse_pkg::*;
  localparam int NB = W / 8;

  logic [W-1:0] sub_d;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    always_comb sub_d[g*8 +: 8] = sbox_byte(din[g*8 +: 8]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else if (en) dout <= sub_d;
  end
endmodule

// File: rtl/aes_wse_colmix.sv
module aes_wse_colmix #(
  parameter int W = 32
) (
  input  logic [W-1:0] sub_w,
  input  logic [W-1:0] key_w,
  input  logic         mix_en,
  output logic [W-1:0] res
);
  import aes_wse_pkg::*;
  always_comb res = (mix_en ? mix_col(sub_w) : sub_w) ^ key_w;
endmodule

// File: rtl/aes_wse_seq.sv
module aes_wse_seq #(
  parameter int NR = 10,
  parameter int NS = 5,
  localparam int RW = $clog2(NR + 1),
  localparam int SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_free,
  output logic          busy,
  output logic [RW-1:0] round,
  output logic [SW-1:0] slot,
  output logic          final_slot,
  output logic          adv,
  output logic          ld,
  output logic          in_ready
);
  always_comb begin
    final_slot = busy && (round == RW'(NR)) && (slot == SW'(NS - 1));
    adv        = busy && (!final_slot || out_free);
    in_ready   = !busy || (final_slot && out_free);
    ld         = in_valid && in_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      round <= '0;
      slot  <= '0;
    end else if (ld) begin
      busy  <= 1'b1;
      round <= RW'(1);
      slot  <= '0;
    end else if (adv) begin
      if (final_slot) begin
        busy <= 1'b0;
      end else if (slot == SW'(NS - 1)) begin
        slot  <= '0;
        round <= round + RW'(1);
      end else begin
        slot <= slot + SW'(1);
      end
    end
  end

  a_r1_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> busy && round == RW'(1) && slot == '0);

  a_r4_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !ld && slot != SW'(NS - 1) |=> slot == $past(slot) + SW'(1) && round == $past(round));

  a_r4_round_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !ld && slot == SW'(NS - 1) && round != RW'(NR) |=> slot == '0 && round == $past(round) + RW'(1));

  a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(round == RW'(NR) && slot == SW'(NS - 1)) |-> !in_ready);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    final_slot && !out_free |=> busy && $stable(round) && $stable(slot));
endmodule

// File: rtl/aes_wse_enc.sv
module aes_wse_enc #(
  parameter int NR = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_key,
  input  logic [127:0] in_text,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_data
);
  import aes_wse_pkg::*;
  localparam int NS = NWORDS + 1;
  localparam int RW = $clog2(NR + 1);
  localparam int SW = $clog2(NS);
  localparam int WI = $clog2(NWORDS);

  logic [BLK_W-1:0]  state_q, key_q, out_q;
  logic              out_valid_q, pend_q;
  logic              out_free;
  logic              busy, final_slot, adv, ld;
  logic [RW-1:0]     round;
  logic [SW-1:0]     slot;
  logic [WORD_W-1:0] issue_w, sub_q, wb_word, wb_key;
  logic [SW-1:0]     slot_m2;
  logic [WI-1:0]     wb_idx;
  logic [RW-1:0]     wb_round;
  logic              mix_en;
  logic              ev_key_upd, ev_wb, ev_shift, ev_out_part;
  logic [BLK_W-1:0]  sr_in;

  assign out_free = !out_valid_q || out_ready;

  aes_wse_seq #(.NR(NR), .NS(NS)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_free(out_free),
    .busy(busy), .round(round), .slot(slot), .final_slot(final_slot),
    .adv(adv), .ld(ld), .in_ready(in_ready)
  );

  // issue: slot 0 carries the rotated last key word, slots 1..4 the state columns
  always_comb begin
    if (slot == '0) issue_w = rot_word(get_word(key_q, NWORDS - 1));
    else            issue_w = get_word(state_q, int'(slot) - 1);
  end

  aes_wse_sbox_pipe #(.W(WORD_W)) u_sbox (
    .clk(clk), .rst_n(rst_n), .en(adv), .din(issue_w), .dout(sub_q)
  );

  // write-back lags its issue by one slot; slot 0 finishes the previous round's last column
  always_comb begin
    slot_m2  = slot - SW'(2);
    wb_idx   = (slot == '0) ? WI'(NWORDS - 1) : slot_m2[WI-1:0];
    wb_round = (slot == '0) ? round - RW'(1) : round;
    mix_en   = (wb_round != RW'(NR));
    wb_key   = get_word(key_q, int'(wb_idx));
  end

  aes_wse_colmix #(.W(WORD_W)) u_mix (
    .sub_w(sub_q), .key_w(wb_key), .mix_en(mix_en), .res(wb_word)
  );

  always_comb begin
    ev_shift    = adv && (slot == '0);
    ev_key_upd  = adv && (slot == SW'(1));
    ev_wb       = adv && !final_slot && (slot >= SW'(2) || (slot == '0 && round != RW'(1)));
    ev_out_part = adv && final_slot;
    sr_in = state_q;
    if (round != RW'(1)) sr_in[WORD_W-1:0] = wb_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      key_q   <= '0;
    end else if (ld) begin
      state_q <= in_text ^ in_key;
      key_q   <= in_key;
    end else if (ev_shift) begin
      state_q <= shift_rows(sr_in);
    end else if (ev_key_upd) begin
      key_q <= next_key(key_q, sub_q, rcon(int'(round)));
    end else if (ev_wb) begin
      state_q[BLK_W-1-WORD_W*int'(wb_idx) -: WORD_W] <= wb_word;
    end
  end

  // final round: three columns plus the last key word go out first, the last column one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q       <= '0;
      out_valid_q <= 1'b0;
      pend_q      <= 1'b0;
    end else if (ev_out_part) begin
      out_q       <= {state_q[BLK_W-1 -: 2*WORD_W], wb_word, get_word(key_q, NWORDS - 1)};
      pend_q      <= 1'b1;
      out_valid_q <= 1'b0;
    end else if (pend_q) begin
      out_q[WORD_W-1:0] <= out_q[WORD_W-1:0] ^ sub_q;
      pend_q            <= 1'b0;
      out_valid_q       <= 1'b1;
    end else if (out_valid_q && out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_q;

  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r3_valid_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
    ev_out_part |=> !out_valid ##1 out_valid);

  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    ev_out_part |-> !out_valid || out_ready);

  a_r4_key_before_cols: assert property (@(posedge clk) disable iff (!rst_n)
    ev_key_upd |=> !ev_shift);
endmodule

// File: tb/aes_wse_enc_bench.sv
module aes_wse_enc_bench;
  logic         clk, rst_n;
  logic         in_valid, in_ready, out_valid, out_ready;
  logic [127:0] in_key, in_text, out_data;

  int total = 0, bad = 0, cyc = 0;
  int wr = 0, rd = 0, or_mode = 0;
  logic [127:0] q_ct [0:63];
  int           q_acc[0:63];
  logic [7:0]   sb   [0:255];
  bit           hold_flag = 0;
  logic [127:0] hold_data;

  aes_wse_enc u_aes_wse_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .in_text(in_text), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return (a << 1) ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0, bb = b;
    for (int i = 0; i < 8; i++) begin
      if (a[i]) p ^= bb;
      bb = xt(bb);
    end
    return p;
  endfunction

  function automatic logic [127:0] ref_aes(input logic [127:0] k, input logic [127:0] p);
    logic [7:0] s[16], t[16], rk[16], tw[4];
    logic [7:0] rc = 8'h01;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) begin
      rk[i] = k[127-8*i -: 8];
      s[i]  = p[127-8*i -: 8] ^ rk[i];
    end
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) s[i] = sb[s[i]];
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) t[4*c+w] = s[4*((c+w)%4)+w];
      if (r < 10) begin
        for (int c = 0; c < 4; c++) begin
          logic [7:0] a0, a1, a2, a3, all;
          a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
          all = a0 ^ a1 ^ a2 ^ a3;
          t[4*c]   = a0 ^ all ^ xt(a0 ^ a1);
          t[4*c+1] = a1 ^ all ^ xt(a1 ^ a2);
          t[4*c+2] = a2 ^ all ^ xt(a2 ^ a3);
          t[4*c+3] = a3 ^ all ^ xt(a3 ^ a0);
        end
      end
      tw[0] = sb[rk[13]] ^ rc; tw[1] = sb[rk[14]]; tw[2] = sb[rk[15]]; tw[3] = sb[rk[12]];
      for (int i = 0; i < 4; i++) rk[i] ^= tw[i];
      for (int i = 4; i < 16; i++) rk[i] ^= rk[i-4];
      rc = xt(rc);
      for (int i = 0; i < 16; i++) s[i] = t[i] ^ rk[i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // output back-pressure, applied shortly after each rising edge
  always @(posedge clk) begin
    #3;
    case (or_mode)
      0: out_ready = 1'b0;
      1: out_ready = 1'b1;
      default: out_ready = ($urandom % 3) != 0;
    endcase
  end

  // monitor samples in the quiet window before each rising edge
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      if (hold_flag) chk(out_valid && out_data == hold_data, "R6 hold", out_data, hold_data);
      hold_flag = out_valid && !out_ready;
      hold_data = out_data;
      if (in_valid && in_ready) begin
        q_ct[wr % 64]  = ref_aes(in_key, in_text);
        q_acc[wr % 64] = cyc + 1;
        wr++;
      end
      if (out_valid && out_ready) begin
        chk(out_data == q_ct[rd % 64], "R2 ciphertext", out_data, q_ct[rd % 64]);
        rd++;
      end
    end
  end

  task automatic send(input logic [127:0] k, input logic [127:0] p);
    bit got = 0;
    in_key = k; in_text = p; in_valid = 1'b1;
    while (!got) begin
      #5;
      got = in_ready;
      @(negedge clk);
    end
  endtask

  task automatic drain();
    int n = 0;
    while (rd != wr && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(rd == wr, "R2 drain", 128'(rd), 128'(wr));
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    finish_up();
  end

  initial begin
    logic [127:0] ea, eb, ka, pa, kb, pb;
    int base, lat;
    void'($urandom(32'h5EED1234));
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 0, o;
      for (int y = 1; y < 256; y++) if (bmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ 8'h63 >> i;
      sb[x] = o;
    end
    rst_n = 1'b0; in_valid = 1'b0; in_key = '0; in_text = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk(!out_valid, "R1 reset out_valid", 128'(out_valid), 0);
    chk(in_ready, "R1 idle in_ready", 128'(in_ready), 1);
    @(negedge clk);

    // known-answer pair, free consumer: latency and value
    or_mode = 1;
    send(128'h000102030405060708090A0B0C0D0E0F, 128'h00112233445566778899AABBCCDDEEFF);
    in_valid = 1'b0;
    repeat (10) begin @(negedge clk); end
    #5;
    chk(!in_ready, "R5 busy in_ready", 128'(in_ready), 0);
    lat = 0;
    while (!out_valid && lat < 200) begin @(negedge clk); #5; lat++; end
    chk(cyc - q_acc[0] == 51, "R3 latency", 128'(cyc - q_acc[0]), 51);
    chk(out_data == 128'h69C4E0D86A7B0430D8CDB78070B4C55A, "R2 known answer", out_data,
        128'h69C4E0D86A7B0430D8CDB78070B4C55A);
    @(negedge clk);
    drain();

    // directed corners then random pairs under random back-pressure
    or_mode = 2;
    for (int i = 0; i < 10; i++) begin
      logic [127:0] k, p;
      k = (i == 0) ? '0 : (i == 1) ? '1 : rnd128();
      p = (i == 0) ? '0 : (i == 1) ? '1 : rnd128();
      send(k, p);
      in_valid = 1'b0;
      repeat ($urandom % 60) @(negedge clk);
    end
    drain();
    or_mode = 1;
    repeat (4) @(negedge clk);

    // stall: second result completes while first is unconsumed
    or_mode = 0;
    ka = rnd128(); pa = rnd128(); kb = rnd128(); pb = rnd128();
    ea = ref_aes(ka, pa); eb = ref_aes(kb, pb);
    send(ka, pa);
    send(kb, pb);
    in_valid = 1'b0;
    repeat (120) @(negedge clk);
    #5;
    chk(out_valid && out_data == ea, "R7 old result held", out_data, ea);
    chk(!in_ready, "R5 stalled in_ready", 128'(in_ready), 0);
    or_mode = 1;
    @(negedge clk); #5;
    chk(in_ready, "R9 in_ready follows out_ready", 128'(in_ready), 1);
    or_mode = 0;
    @(negedge clk); #5;
    chk(!out_valid, "R7 one-cycle gap", 128'(out_valid), 0);
    @(negedge clk); #5;
    chk(out_valid && out_data == eb, "R7 resumed result", out_data, eb);
    or_mode = 1;
    @(negedge clk);
    drain();

    // back-to-back pairs with a free consumer
    base = wr;
    for (int i = 0; i < 5; i++) send(rnd128(), rnd128());
    in_valid = 1'b0;
    @(negedge clk);
    for (int i = 1; i < 5; i++)
      chk(q_acc[(base+i)%64] - q_acc[(base+i-1)%64] == 50, "R8 spacing",
          128'(q_acc[(base+i)%64] - q_acc[(base+i-1)%64]), 50);
    drain();
    finish_up();
  end
endmodule